// File: doc/BRIEF.md
# Command-Driven Memory Burst Reader

The block takes read commands from a first-word-fall-through command FIFO. Each command names a start address and an element count. The block reads that many consecutive words from an on-chip RAM, then pushes every returned word, in order, into an output FIFO. The RAM has a registered read port: data for an address issued in one cycle is valid in the next cycle. Only one command is in progress at a time.

The control is a two-state machine. In `ST_IDLE` the block waits for the command FIFO to show an entry. It pops the entry in the same cycle and latches the start address and the count. In that cycle it also clears an offset counter. The transition *take* (IDLE to READ) fires on a pop with a non-zero count. A pop with a zero count keeps the machine in IDLE. In `ST_READ` the block issues one RAM read per cycle at start plus offset, and the offset then advances. The transition *finish* (READ to IDLE) fires on the read that carries the last offset.

A read is issued only while the output FIFO reports room and the holding register is empty. The push of each word follows its read by one cycle. If the FIFO fills while a word is in flight, that word waits in the holding register and is pushed as soon as room returns.

Top module: `burst_rd_engine`

## Requirements
- R1: After reset, with the command FIFO empty, `cmd_pop`, `ram_re` and `out_push` are all low.
- R2: In IDLE, `cmd_pop` is high in every cycle where `cmd_empty` is low. The start address and the count are taken from `cmd_addr` and `cmd_len` in that same cycle. A non-zero count moves the block to READ on the next cycle.
- R3: A command with `cmd_len` equal to 0 is popped without any RAM read or push. The block stays in IDLE, so a queued next command is popped in the following cycle.
- R4: The k-th read of a burst (k counted from 0) uses address (start + k) modulo 2^ADDR_W. The reads of a burst go to consecutive addresses.
- R5: A command with count N produces exactly N pushes before the block returns to IDLE. No new command is popped while reads of the current one remain, so at most one word of an earlier command is still outstanding when a pop happens.
- R6: With `out_full` low, the first read issues the cycle after the pop, and every read is followed by its push one cycle later. The first push therefore comes two cycles after the pop, and bursts stream at one word per cycle.
- R7: No read issues and no push occurs in a cycle where `out_full` is high. A word in flight when the FIFO fills is held and pushed later, with no loss and no reordering.
- R8: `out_data` on each push equals the 64-bit RAM word at that push's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_empty | input | 1 | Command FIFO has no entry |
| cmd_pop | output | 1 | Consume the command FIFO head this cycle |
| cmd_addr | input | ADDR_W (8) | Start address of the head command |
| cmd_len | input | CNT_W (9) | Element count of the head command |
| ram_re | output | 1 | RAM read strobe |
| ram_addr | output | ADDR_W (8) | RAM read address |
| ram_rdata | input | DATA_W (64) | RAM read data, valid one cycle after `ram_re` |
| out_full | input | 1 | Output FIFO cannot accept a word |
| out_push | output | 1 | Write `out_data` into the output FIFO |
| out_data | output | DATA_W (64) | Word being pushed |

## Verification
The bench samples at the falling edge, counts cycles, and knows from R6 that a push is due exactly one cycle after a read strobe while `out_full` is low. It also knows that the first push of an unstalled burst comes two cycles after its pop. It records the pop cycle and requires a push at pop+2. A zero-count command must be followed by the next pop in the very next cycle. Each pushed word is compared with the head of an expected-word queue, which is filled at pop time from the address formula of R4. This catches a wrong address, a lost word or a reordered word, whenever the push happens.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_READ = 1'b1
    } rd_state_e;
endpackage

// File: rtl/burst_rd_fsm.sv
module burst_rd_fsm
    import burst_rd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_empty,
    input  logic      len_zero,
    input  logic      issue,
    input  logic      last_beat,
    output rd_state_e state,
    output logic      cmd_pop
);
    rd_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (!cmd_empty && !len_zero) state_nx = ST_READ;  // take
            ST_READ: if (issue && last_beat)      state_nx = ST_IDLE;  // finish
            default:                              state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_pop = (state == ST_IDLE) && !cmd_empty;
    end

    AST_ZERO_LEN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pop && len_zero) |=> (state == ST_IDLE)); // R3
    AST_POP_ENTERS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pop && !len_zero) |=> (state == ST_READ)); // R2
    AST_NO_POP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !last_beat) |=> !cmd_pop); // R5
endmodule

// File: rtl/burst_rd_cursor.sv
module burst_rd_cursor #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_len,
    input  logic              issue,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              last_beat
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  len_q;
    logic [CNT_W-1:0]  offs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            offs_q <= '0;
        end else if (load) begin
            base_q <= cmd_addr;
            len_q  <= cmd_len;
            offs_q <= '0;
        end else if (issue) begin
            offs_q <= offs_q + ONE;
        end
    end

    always_comb begin
        ram_addr  = base_q + ADDR_W'(offs_q);
        last_beat = ((offs_q + ONE) == len_q);
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && $past(issue)) |-> (ram_addr == $past(ram_addr) + ADDR_W'(1))); // R4
    AST_OFFS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (offs_q == '0)); // R2
    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (offs_q < len_q)); // R5
endmodule

// File: rtl/burst_rd_outstage.sv
module burst_rd_outstage #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              out_full,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              hold_vld,
    output logic              out_push,
    output logic [DATA_W-1:0] out_data
);
    logic              pend_q;
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            hold_vld <= 1'b0;
            hold_q   <= '0;
        end else begin
            pend_q <= issue;
            if (pend_q && out_full) begin
                hold_vld <= 1'b1;
                hold_q   <= ram_rdata;
            end else if (hold_vld && !out_full) begin
                hold_vld <= 1'b0;
            end
        end
    end

    always_comb begin
        out_push = (pend_q || hold_vld) && !out_full;
        out_data = hold_vld ? hold_q : ram_rdata;
    end

    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_full |-> !out_push); // R7
    AST_PUSH_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue) && !out_full) |-> out_push); // R6
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && out_full) |=> (hold_vld && $stable(out_data))); // R7
endmodule

// File: rtl/burst_rd_engine.sv
module burst_rd_engine
    import burst_rd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_empty,
    output logic              cmd_pop,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_len,
    output logic              ram_re,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              out_full,
    output logic              out_push,
    output logic [DATA_W-1:0] out_data
);
    rd_state_e state;
    logic      len_zero;
    logic      last_beat;
    logic      hold_vld;
    logic      issue;

    always_comb begin
        len_zero = (cmd_len == '0);
        issue    = (state == ST_READ) && !out_full && !hold_vld;
        ram_re   = issue;
    end

    burst_rd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_empty (cmd_empty),
        .len_zero  (len_zero),
        .issue     (issue),
        .last_beat (last_beat),
        .state     (state),
        .cmd_pop   (cmd_pop)
    );

    burst_rd_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cmd_pop),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .issue     (issue),
        .ram_addr  (ram_addr),
        .last_beat (last_beat)
    );

    burst_rd_outstage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .out_full  (out_full),
        .ram_rdata (ram_rdata),
        .hold_vld  (hold_vld),
        .out_push  (out_push),
        .out_data  (out_data)
    );

    AST_NO_READ_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_full |-> !ram_re); // R7
    AST_FIRST_READ_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pop && !len_zero && !out_full) |=> (out_full || ram_re)); // R6
endmodule

// File: tb/burst_rd_engine_tb_top.sv
module burst_rd_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_empty = 1'b1;
    logic              cmd_pop;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [CNT_W-1:0]  cmd_len = '0;
    logic              ram_re;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_rdata = '0;
    logic              out_full = 1'b0;
    logic              out_push;
    logic [DATA_W-1:0] out_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int due = -1;
    int zero_cyc = -10;
    logic prev_re = 1'b0;
    bit full_rand = 0;

    logic [ADDR_W-1:0] q_addr[$];
    logic [CNT_W-1:0]  q_len[$];
    logic [DATA_W-1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_rd_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_empty(cmd_empty), .cmd_pop(cmd_pop),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .ram_re(ram_re), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .out_full(out_full), .out_push(out_push), .out_data(out_data)
    );

    function automatic logic [DATA_W-1:0] word_at(input logic [ADDR_W-1:0] a);
        logic [31:0] x;
        x = 32'(a);
        return {x * 32'h9E37_79B1, ~x ^ 32'h00C0_FFEE};
    endfunction

    always @(posedge clk) begin
        if (ram_re) ram_rdata <= word_at(ram_addr);
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic drive_cmd();
        cmd_empty = (q_addr.size() == 0);
        cmd_addr  = cmd_empty ? '0 : q_addr[0];
        cmd_len   = cmd_empty ? '0 : q_len[0];
    endtask

    task automatic add_cmd(input int a, input int l);
        q_addr.push_back(ADDR_W'(a));
        q_len.push_back(CNT_W'(l));
        drive_cmd();
    endtask

    task automatic step();
        bit do_pop;
        logic [DATA_W-1:0] e;
        @(negedge clk);
        cyc++;
        do_pop = 0;
        if (ram_re) check(!out_full, "R7 read while full", 64'(ram_re), 64'd0);
        if (out_push) begin
            check(!out_full, "R7 push while full", 64'(out_push), 64'd0);
            if (exp_q.size() == 0) begin
                check(0, "R5 extra push", out_data, 64'd0);
            end else begin
                e = exp_q.pop_front();
                check(out_data == e, "R8/R4 data", out_data, e);
            end
        end
        if (prev_re && !out_full) check(out_push, "R6 push after read", 64'(out_push), 64'd1);
        if (due == cyc) begin
            check(out_push, "R6 first push at pop+2", 64'(out_push), 64'd1);
            due = -1;
        end
        if (zero_cyc + 1 == cyc) begin
            check(!ram_re, "R3 no read after zero count", 64'(ram_re), 64'd0);
            if (q_addr.size() != 0)
                check(cmd_pop, "R3 next pop follows", 64'(cmd_pop), 64'd1);
        end
        if (!cmd_empty && q_addr.size() != 0 && !cmd_pop && !ram_re && !out_push
            && exp_q.size() == 0 && !prev_re)
            check(0, "R2 idle without pop", 64'(cmd_pop), 64'd1);
        if (cmd_pop) begin
            check(q_addr.size() != 0, "R2 pop of empty", 64'(cmd_pop), 64'd0);
            check(exp_q.size() <= 1, "R5 pop while burst open", 64'(exp_q.size()), 64'd1);
            if (q_addr.size() != 0) begin
                if (q_len[0] == 0) zero_cyc = cyc;
                else if (!full_rand) due = cyc + 2;
                for (int k = 0; k < int'(q_len[0]); k++)
                    exp_q.push_back(word_at(ADDR_W'(int'(q_addr[0]) + k)));
                do_pop = 1;
            end
        end
        prev_re = ram_re;
        @(posedge clk);
        #1;
        if (do_pop) begin
            void'(q_addr.pop_front());
            void'(q_len.pop_front());
        end
        drive_cmd();
        out_full = full_rand ? ($urandom % 100 < 35) : 1'b0;
    endtask

    task automatic drain();
        full_rand = 0;
        out_full  = 1'b0;
        for (int i = 0; i < 600 && (q_addr.size() != 0 || exp_q.size() != 0); i++) step();
        repeat (4) step();
        check(exp_q.size() == 0, "R5 all words pushed", 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_pop && !ram_re && !out_push, "R1 reset outputs",
              {61'd0, cmd_pop, ram_re, out_push}, 64'd0);
        @(posedge clk); #1;

        // R6 R4 R8: plain burst, no back-pressure
        add_cmd(3, 4);
        drain();
        // R3: zero count then a real command
        add_cmd(40, 0);
        add_cmd(41, 2);
        drain();
        // R4: wrap past the top of the address space
        add_cmd(250, 10);
        drain();
        // single-element burst followed back to back by another
        add_cmd(7, 1);
        add_cmd(100, 3);
        drain();
        // R7: output FIFO full for a stretch in mid-burst
        add_cmd(20, 6);
        step(); step(); step();
        out_full = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); cyc++;
            check(!out_push && !ram_re, "R7 stalled while full",
                  {62'd0, out_push, ram_re}, 64'd0);
            if (out_push && exp_q.size() != 0) void'(exp_q.pop_front());
            prev_re = 1'b0;
            @(posedge clk); #1;
        end
        drain();
        // random commands under random back-pressure
        full_rand = 1;
        for (int n = 0; n < 60; n++) begin
            add_cmd($urandom % 256, ($urandom % 5 == 0) ? 0 : ($urandom % 24) + 1);
            for (int i = 0; i < int'($urandom % 12); i++) step();
        end
        for (int i = 0; i < 400; i++) step();
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule